// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the carrier timing for a pulse-width modulator. A 16-bit counter advances once per prescaled tick. The prescaler divides the input clock by the product of two factors. The first is a power of two. The second is an even divider, where a setting of zero means divide by one. The counter can count up and wrap, count down and wrap, count up-down as a triangle wave, or be frozen. Downstream compare logic uses the live count, the count direction, and single-clock strobes that mark the counter arriving at zero and arriving at the period value.

Software programs the block through one synchronous write port, which selects one of three registers:

- **Control word.** Holds the counting mode, both prescale factors, the period-load policy, the phase-enable bit and the phase direction.
- **Period.** Holds the number of ticks per carrier cycle minus one. A newly written period is either shadowed until the counter next arrives at zero, or applied on the next prescaled tick.
- **Phase value.** When phase loading is enabled, a one-clock sync pulse jams the counter to this value and sets the direction to the stored phase direction.

Top module: `pwm_timebase`

## Requirements
- R1: Asynchronous reset (rst_n low) clears the count to 0, sets dir_up to 1 and holds both strobes low. It also selects frozen mode, so the count stays at 0 until software writes the control word. The period registers reset to 999.
- R2: Register select codes on wr_sel are: 0 = control word, 1 = period, 2 = phase value, 3 = ignored. Control word fields are:
  - bits 1:0: mode (0 up, 1 down, 2 up-down, 3 frozen).
  - bits 4:2: k.
  - bits 7:5: h.
  - bit 8: immediate period load.
  - bit 9: phase enable.
  - bit 10: phase direction.
  
  The counter moves once every 2^k * (h==0 ? 1 : 2h) clock cycles, for a ratio between 1 and 1792.
- R3: In up mode, the count steps 0, 1, …, P and then returns to 0, where P is the active period. dir_up reads 1.
- R4: In down mode, the count steps down to 0 and then reloads P. dir_up reads 0.
- R5: In up-down mode, the count runs 0 to P and back to 0 without repeating either endpoint. The direction flips on the tick that leaves an endpoint, so dir_up is still 1 while the count sits at P and still 0 while it sits at 0.
- R6: In frozen mode, the count and dir_up hold their values and neither strobe fires.
- R7: zero_evt is high for exactly the first clock in which a counting tick has brought the count to 0. prd_evt behaves the same way for the count arriving at the active period. At all other times both strobes are low.
- R8: With bit 8 of the control word clear, a written period becomes active only on the counting tick that brings the count to 0.
- R9: With bit 8 set, a written period becomes active on the next prescaled tick. The count then runs past the old period without wrapping.
- R10: With bit 9 set, a one-clock sync_in pulse loads the phase value into the count on the next edge and sets dir_up from bit 10. It also restarts the prescaler and holds both strobes low for that clock.
- R11: With bit 9 clear, sync_in has no effect, and writing the phase value alone never changes the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 period, 2 phase |
| wr_data | input | 16 | Write data |
| sync_in | input | 1 | One-clock phase-load pulse |
| count | output | 16 | Live counter value |
| dir_up | output | 1 | Count direction, 1 = up |
| zero_evt | output | 1 | Counter arrived at zero |
| prd_evt | output | 1 | Counter arrived at period |

## Verification
The bench checks the shadowed period against the immediate one around a wrap. A design that applied a shadowed period early would wrap at the new value before the count next reached zero. A design that delayed an immediate load would wrap at the old period instead of running past it. Prescale gaps are measured at the smallest ratio, a mid ratio and the largest ratio. An off-by-one in the divider shows up there as a gap one clock too long. The up-down endpoints are checked for repeated values and for the direction flag. The phase jam is checked for taking hold without phase enable, and for a prescaler that did not restart after the load.

// File: rtl/pwm_tb_pkg.sv
`timescale 1ns/1ps
package pwm_tb_pkg;
  localparam int PS_POW_W  = 3;
  localparam int PS_EVEN_W = 3;

  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_UPDOWN = 2'd2,
    MODE_FROZEN = 2'd3
  } tb_mode_e;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_PRD   = 2'd1;
  localparam logic [1:0] SEL_PHASE = 2'd2;

  typedef struct packed {
    logic                 phase_dir;
    logic                 phase_en;
    logic                 prd_imm;
    logic [PS_EVEN_W-1:0] div_even;
    logic [PS_POW_W-1:0]  div_pow;
    tb_mode_e             mode;
  } tb_ctrl_t;

  localparam int CTRL_W = $bits(tb_ctrl_t);
  localparam tb_ctrl_t CTRL_RESET = '{phase_dir: 1'b0, phase_en: 1'b0, prd_imm: 1'b0,
                                      div_even: '0, div_pow: '0, mode: MODE_FROZEN};

  localparam int POW_MAX  = 2**PS_POW_W - 1;
  localparam int EVEN_MAX = 2 * (2**PS_EVEN_W - 1);
  localparam int RATIO_W  = POW_MAX + $clog2(EVEN_MAX) + 1;

  // Total clock division of the two prescale stages.
  function automatic logic [RATIO_W-1:0] div_ratio(input logic [PS_POW_W-1:0] k,
                                                   input logic [PS_EVEN_W-1:0] h);
    logic [RATIO_W-1:0] pw;
    logic [RATIO_W-1:0] ev;
    pw = RATIO_W'(1) << k;
    ev = (h == '0) ? RATIO_W'(1) : RATIO_W'({h, 1'b0});
    return RATIO_W'(pw * ev);
  endfunction
endpackage

// File: rtl/pwm_tb_prescaler.sv
`timescale 1ns/1ps
module pwm_tb_prescaler
  import pwm_tb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PS_POW_W-1:0]  div_pow,
  input  logic [PS_EVEN_W-1:0] div_even,
  input  logic                 restart,
  output logic                 tick,
  output logic [RATIO_W-1:0]   ratio
);
  logic [RATIO_W-1:0] pcnt;

  assign ratio = div_ratio(div_pow, div_even);
  // A shrinking ratio never strands the divider: any value at or past the limit ticks.
  assign tick  = (pcnt >= ratio - RATIO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (restart || tick) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + RATIO_W'(1);
    end
  end
endmodule

// File: rtl/pwm_tb_ctrl_regs.sv
`timescale 1ns/1ps
module pwm_tb_ctrl_regs
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int unsigned PRD_RESET = 999
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             adv,
  input  logic             enters_zero,
  output tb_ctrl_t         ctrl,
  output logic [CNT_W-1:0] prd_active,
  output logic [CNT_W-1:0] phase_val
);
  logic [CNT_W-1:0] prd_shadow;
  logic             prd_pend;
  logic             wr_ctrl, wr_prd, wr_phase;
  logic             prd_xfer;

  assign wr_ctrl  = wr_en && (wr_sel == SEL_CTRL);
  assign wr_prd   = wr_en && (wr_sel == SEL_PRD);
  assign wr_phase = wr_en && (wr_sel == SEL_PHASE);
  // Transfer policy: immediate on any tick, shadowed only on arrival at zero.
  assign prd_xfer = prd_pend && (ctrl.prd_imm ? adv : enters_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= CTRL_RESET;
    end else if (wr_ctrl) begin
      ctrl <= tb_ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_shadow <= CNT_W'(PRD_RESET);
      prd_active <= CNT_W'(PRD_RESET);
      prd_pend   <= 1'b0;
    end else if (wr_prd) begin
      prd_shadow <= wr_data;
      prd_pend   <= 1'b1;
    end else if (prd_xfer) begin
      prd_active <= prd_shadow;
      prd_pend   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_val <= '0;
    end else if (wr_phase) begin
      phase_val <= wr_data;
    end
  end
endmodule

// File: rtl/pwm_tb_counter.sv
`timescale 1ns/1ps
module pwm_tb_counter
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  tb_mode_e         mode,
  input  logic [CNT_W-1:0] prd,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_dir,
  output logic [CNT_W-1:0] count,
  output logic             dir_up,
  output logic             zero_evt,
  output logic             prd_evt,
  output logic             enters_zero
);
  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic             dir;
  } step_t;

  // One counting step for the given mode; direction flips when leaving an endpoint.
  function automatic step_t next_step(input tb_mode_e m, input logic [CNT_W-1:0] c,
                                      input logic [CNT_W-1:0] p, input logic d);
    step_t s;
    s.cnt = c;
    s.dir = d;
    case (m)
      MODE_UP: begin
        s.dir = 1'b1;
        s.cnt = (c >= p) ? '0 : c + CNT_W'(1);
      end
      MODE_DOWN: begin
        s.dir = 1'b0;
        s.cnt = (c == '0) ? p : c - CNT_W'(1);
      end
      MODE_UPDOWN: begin
        if (d) begin
          if (c >= p) begin
            s.dir = 1'b0;
            s.cnt = (c == '0) ? '0 : c - CNT_W'(1);
          end else begin
            s.cnt = c + CNT_W'(1);
          end
        end else begin
          if (c == '0) begin
            s.dir = 1'b1;
            s.cnt = (p == '0) ? '0 : CNT_W'(1);
          end else begin
            s.cnt = c - CNT_W'(1);
          end
        end
      end
      default: ;
    endcase
    return s;
  endfunction

  step_t nxt;
  logic  counting;

  always_comb nxt = next_step(mode, count, prd, dir_up);
  assign counting    = adv && (mode != MODE_FROZEN);
  assign enters_zero = counting && (nxt.cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      dir_up   <= 1'b1;
      zero_evt <= 1'b0;
      prd_evt  <= 1'b0;
    end else if (load) begin
      count    <= load_val;
      dir_up   <= load_dir;
      zero_evt <= 1'b0;
      prd_evt  <= 1'b0;
    end else if (counting) begin
      count    <= nxt.cnt;
      dir_up   <= nxt.dir;
      zero_evt <= (nxt.cnt == '0);
      prd_evt  <= (nxt.cnt == prd);
    end else begin
      zero_evt <= 1'b0;
      prd_evt  <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int unsigned PRD_RESET = 999
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             sync_in,
  output logic [CNT_W-1:0] count,
  output logic             dir_up,
  output logic             zero_evt,
  output logic             prd_evt
);
  tb_ctrl_t           ctrl;
  tb_mode_e           mode;
  logic               prd_imm;
  logic               phase_dir;
  logic [CNT_W-1:0]   prd_active;
  logic [CNT_W-1:0]   phase_val;
  logic [RATIO_W-1:0] ratio;
  logic               tick;
  logic               adv;
  logic               phase_load;
  logic               enters_zero;

  assign mode       = ctrl.mode;
  assign prd_imm    = ctrl.prd_imm;
  assign phase_dir  = ctrl.phase_dir;
  assign phase_load = sync_in && ctrl.phase_en;
  assign adv        = tick && !phase_load;

  pwm_tb_ctrl_regs #(.CNT_W(CNT_W), .PRD_RESET(PRD_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .adv(adv), .enters_zero(enters_zero), .ctrl(ctrl),
    .prd_active(prd_active), .phase_val(phase_val)
  );

  pwm_tb_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .div_pow(ctrl.div_pow), .div_even(ctrl.div_even),
    .restart(phase_load), .tick(tick), .ratio(ratio)
  );

  pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(adv), .mode(mode), .prd(prd_active),
    .load(phase_load), .load_val(phase_val), .load_dir(phase_dir),
    .count(count), .dir_up(dir_up), .zero_evt(zero_evt), .prd_evt(prd_evt),
    .enters_zero(enters_zero)
  );
endmodule

// File: rtl/pwm_timebase_chk.sv
`timescale 1ns/1ps
module pwm_timebase_chk
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CNT_W-1:0]   count,
  input logic               dir_up,
  input logic               zero_evt,
  input logic               prd_evt,
  input logic               tick,
  input logic               adv,
  input logic               phase_load,
  input tb_mode_e           mode,
  input logic [RATIO_W-1:0] ratio,
  input logic [CNT_W-1:0]   prd_active,
  input logic               prd_imm,
  input logic [CNT_W-1:0]   phase_val,
  input logic               phase_dir
);
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || ratio == RATIO_W'(1)));

  assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode == MODE_UP && count < prd_active) |=> (count == $past(count) + CNT_W'(1)));

  assert_down_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode == MODE_DOWN) |=> !dir_up);

  assert_no_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode == MODE_UPDOWN && prd_active != '0) |=> (count != $past(count)));

  assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FROZEN && !phase_load) |=> ($stable(count) && !zero_evt && !prd_evt));

  assert_zero_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |-> (count == '0));

  assert_shadow_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((prd_active != $past(prd_active)) && !$past(prd_imm)) |-> (count == '0));

  assert_phase_jam_R10: assert property (@(posedge clk) disable iff (!rst_n)
    phase_load |=> (count == $past(phase_val) && dir_up == $past(phase_dir) && !zero_evt));
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .dir_up(dir_up), .zero_evt(zero_evt),
  .prd_evt(prd_evt), .tick(tick), .adv(adv), .phase_load(phase_load), .mode(mode),
  .ratio(ratio), .prd_active(prd_active), .prd_imm(prd_imm), .phase_val(phase_val),
  .phase_dir(phase_dir)
);

// File: tb/test_pwm_timebase.sv
`timescale 1ns/1ps
module test_pwm_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        sync_in = 1'b0;
  logic [15:0] count;
  logic        dir_up, zero_evt, prd_evt;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwm_timebase i_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sync_in(sync_in), .count(count), .dir_up(dir_up), .zero_evt(zero_evt), .prd_evt(prd_evt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge from the driven inputs.
  int m_mode = 3, m_k = 0, m_h = 0, m_imm = 0, m_phen = 0, m_phdir = 0;
  int m_pcnt = 0, m_cnt = 0, m_dir = 1, m_sh = 999, m_act = 999, m_pend = 0, m_phase = 0;
  int m_zev = 0, m_pev = 0;

  always @(posedge clk) begin : model
    int ratio, nc, nd, nz, np;
    bit tk, ld, wprd;
    if (!rst_n) begin
      m_mode = 3; m_k = 0; m_h = 0; m_imm = 0; m_phen = 0; m_phdir = 0;
      m_pcnt = 0; m_cnt = 0; m_dir = 1; m_sh = 999; m_act = 999; m_pend = 0;
      m_phase = 0; m_zev = 0; m_pev = 0;
    end else begin
      ratio = (1 << m_k) * ((m_h == 0) ? 1 : 2 * m_h);
      tk = (m_pcnt >= ratio - 1);
      ld = sync_in && (m_phen != 0);
      wprd = wr_en && (wr_sel == 2'd1);
      nz = 0; np = 0;
      if (ld) begin
        m_cnt = m_phase; m_dir = m_phdir; m_pcnt = 0;
      end else begin
        m_pcnt = tk ? 0 : m_pcnt + 1;
        if (tk && m_mode != 3) begin
          nc = m_cnt; nd = m_dir;
          if (m_mode == 0) begin nd = 1; nc = (m_cnt >= m_act) ? 0 : m_cnt + 1; end
          else if (m_mode == 1) begin nd = 0; nc = (m_cnt == 0) ? m_act : m_cnt - 1; end
          else if (m_dir == 1) begin
            if (m_cnt >= m_act) begin nd = 0; nc = (m_cnt > 0) ? m_cnt - 1 : 0; end
            else nc = m_cnt + 1;
          end else begin
            if (m_cnt == 0) begin nd = 1; nc = (m_act > 0) ? 1 : 0; end
            else nc = m_cnt - 1;
          end
          nz = (nc == 0); np = (nc == m_act);
          if (m_pend && !m_imm && nc == 0 && !wprd) begin m_act = m_sh; m_pend = 0; end
          m_cnt = nc; m_dir = nd;
        end
        if (tk && m_imm && m_pend && !wprd) begin m_act = m_sh; m_pend = 0; end
      end
      m_zev = nz; m_pev = np;
      if (wr_en) begin
        if (wr_sel == 2'd0) begin
          m_mode = wr_data[1:0]; m_k = wr_data[4:2]; m_h = wr_data[7:5];
          m_imm = wr_data[8]; m_phen = wr_data[9]; m_phdir = wr_data[10];
        end else if (wr_sel == 2'd1) begin m_sh = wr_data; m_pend = 1; end
        else if (wr_sel == 2'd2) m_phase = wr_data;
      end
    end
  end

  // Every-clock comparison against the model, sampled mid-cycle.
  always @(negedge clk) begin
    string tag;
    if (rst_n && !finished) begin
      case (m_mode)
        0: tag = "R3"; 1: tag = "R4"; 2: tag = "R5"; default: tag = "R6";
      endcase
      check(count == m_cnt[15:0], {tag, " count"}, count, m_cnt);
      check(dir_up == m_dir[0], {tag, " dir_up"}, dir_up, m_dir);
      check(zero_evt == m_zev[0], "R7 zero_evt", zero_evt, m_zev);
      check(prd_evt == m_pev[0], "R7 prd_evt", prd_evt, m_pev);
    end
  end

  function automatic logic [15:0] cw(input int mode, input int k, input int h,
                                     input int imm, input int en, input int dir);
    return 16'((dir << 10) | (en << 9) | (imm << 8) | (h << 5) | (k << 2) | mode);
  endfunction

  task automatic write_reg(input logic [1:0] sel, input logic [15:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_count(input int v);
    for (int i = 0; i < 5000 && count != v; i++) @(negedge clk);
  endtask

  task automatic measure_gap(output int gap);
    logic [15:0] prev;
    prev = count;
    for (int i = 0; i < 5000 && count == prev; i++) @(negedge clk);
    prev = count; gap = 0;
    for (int i = 0; i < 5000 && count == prev; i++) begin @(negedge clk); gap++; end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int mx, gap, minv, maxv, rep, c0, zs;
    bit ok;
    repeat (3) @(negedge clk);
    check(count == 0 && dir_up && !zero_evt && !prd_evt, "R1 reset outputs", count, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(count == 0, "R1 frozen after reset", count, 0);

    // R8: shadowed period waits for the wrap of the reset period.
    write_reg(2'd1, 16'd5);
    write_reg(2'd0, cw(0, 0, 0, 0, 0, 0));
    repeat (20) @(negedge clk);
    check(count > 5, "R8 shadow not yet active", count, 20);
    for (int i = 0; i < 2000 && !zero_evt; i++) @(negedge clk);
    mx = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (count > mx) mx = count; end
    check(mx == 5, "R8 period after wrap", mx, 5);

    // R3: wrap from period to zero with strobe.
    wait_count(5);
    check(prd_evt == 1'b1, "R7 prd_evt at period", prd_evt, 1);
    @(negedge clk);
    check(count == 0 && zero_evt && dir_up, "R3 wrap to zero", count, 0);

    // R2: prescale gaps.
    write_reg(2'd0, cw(0, 2, 3, 0, 0, 0));
    measure_gap(gap); measure_gap(gap);
    check(gap == 24, "R2 ratio k2 h3", gap, 24);
    write_reg(2'd0, cw(0, 1, 0, 0, 0, 0));
    measure_gap(gap); measure_gap(gap);
    check(gap == 2, "R2 ratio k1 h0", gap, 2);
    write_reg(2'd0, cw(0, 7, 7, 0, 0, 0));
    measure_gap(gap); measure_gap(gap);
    check(gap == 1792, "R2 ratio k7 h7", gap, 1792);
    write_reg(2'd0, cw(0, 0, 0, 0, 0, 0));
    measure_gap(gap);
    check(gap == 1, "R2 ratio one", gap, 1);

    // R4: down mode reload.
    write_reg(2'd0, cw(1, 0, 0, 0, 0, 0));
    wait_count(0);
    @(negedge clk);
    check(count == 5 && !dir_up, "R4 reload period", count, 5);

    // R5: up-down triangle.
    write_reg(2'd0, cw(2, 0, 0, 0, 0, 0));
    minv = 99; maxv = 0; rep = 0; c0 = count;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (count == c0) rep++;
      c0 = count;
      if (count < minv) minv = count;
      if (count > maxv) maxv = count;
    end
    check(rep == 0, "R5 no repeated endpoint", rep, 0);
    check(minv == 0 && maxv == 5, "R5 span", maxv, 5);
    wait_count(5);
    check(dir_up == 1'b1, "R5 dir at top", dir_up, 1);

    // R6: frozen hold.
    write_reg(2'd0, cw(3, 0, 0, 0, 0, 0));
    c0 = count; ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (count != c0 || zero_evt || prd_evt) ok = 1'b0;
    end
    check(ok, "R6 frozen holds", count, c0);

    // R9: immediate period load runs past the old period.
    write_reg(2'd0, cw(0, 0, 0, 1, 0, 0));
    wait_count(1);
    write_reg(2'd1, 16'd300);
    mx = 0; zs = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (zero_evt) zs++;
      if (count > mx) mx = count;
    end
    check(zs == 0 && mx > 5, "R9 immediate period", mx, 17);

    // R10: phase jam with direction.
    write_reg(2'd2, 16'd100);
    write_reg(2'd0, cw(2, 0, 0, 1, 1, 0));
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    check(count == 100 && !dir_up && !zero_evt, "R10 phase load", count, 100);
    @(negedge clk);
    check(count == 99, "R10 count after load", count, 99);

    // R11: sync ignored without phase enable; phase write alone is inert.
    write_reg(2'd0, cw(0, 0, 0, 1, 0, 0));
    write_reg(2'd2, 16'd7);
    c0 = count;
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    check(count == c0 + 1, "R11 sync ignored", count, c0 + 1);
    repeat (5) @(negedge clk);
    check(count == c0 + 6, "R11 phase inert", count, c0 + 6);

    finish_run();
  end
endmodule